// File: doc/BRIEF.md
# Three-Deep Payload Queue with Pulse-Started Transmit

This block sits between a byte-serial host command port and a simple radio-side handshake. It keeps two small queues of fixed-width payloads, one outbound and one inbound, each holding at most three complete payloads. The width is set by `cfg_len` (1 to 32 bytes). The host frames each command with `hst_cs`. The first byte of a frame is an opcode, and every byte the host sends is answered one cycle later on `hst_dout`.

The host loads an outbound payload by sending the load opcode and then the payload bytes. Outbound transmission starts only when the chip-enable input `ce` has stayed high for a minimum number of clock cycles and then returns low. The head payload is then streamed on the air-side byte port. After the air side reports completion on `air_tx_done`, the payload is removed from the queue. In reuse mode it stays at the head and is sent again on the next pulse.

Inbound payloads arrive byte by byte from the air side. The host reads them with the read opcode, sending one dummy byte per payload byte. Flush commands empty either queue, and a status command returns the empty and full flags of both queues together with the reuse flag.

Top module: `pfq_payload_fifo`

## Requirements
- R1: After reset both queues are empty and not full, reuse mode is off and `air_tx_valid` is low.
- R2: Opcode 0xA0 followed by `cfg_len` bytes stores one outbound payload. `tx_full` is high exactly when three payloads are stored.
- R3: A payload loaded while the outbound queue is full is discarded. The stored payloads and their order are unchanged.
- R4: When `ce` was sampled high on at least `CE_MIN_CYC` consecutive rising edges and then goes low, the head outbound payload is streamed on `air_tx_data` in load order, with `air_tx_last` on its final byte. A shorter pulse, or a pulse while the queue is empty, produces no output.
- R5: When `air_tx_done` is seen after a payload has been streamed, that payload is popped, and the next pulse sends the following payload.
- R6: Opcode 0xE3 turns reuse mode on. While reuse mode is on, a completed send does not pop the head, so the same payload is sent again.
- R7: Opcode 0xE1 empties the outbound queue and opcode 0xE2 empties the inbound queue. Either one turns reuse mode off.
- R8: Air-side bytes with `air_rx_sop` on the first byte store one inbound payload after `cfg_len` bytes. A payload that starts while three are stored is dropped. `rx_full` is high exactly when three payloads are stored.
- R9: Opcode 0x61 followed by `cfg_len` dummy bytes returns the head inbound payload, one byte per dummy, and then pops it. When the inbound queue is empty the replies are 0x00 and nothing changes.
- R10: The reply to every opcode byte is the status byte. After opcode 0x17, the next byte is also answered with the status byte. The status byte has bit0 for inbound empty, bit1 for inbound full, bit4 for outbound empty, bit5 for outbound full and bit6 for reuse mode, and all other bits are zero.
- R11: When an outbound payload completes its load in the same cycle that a sent payload is popped, the stored count stays correct and the order is kept.
- R12: `hst_dvld` pulses one cycle after every byte accepted while `hst_cs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 6 | Payload width in bytes (1 to 32) |
| hst_cs | input | 1 | Host frame active |
| hst_vld | input | 1 | Host byte strobe |
| hst_din | input | 8 | Host byte |
| hst_dvld | output | 1 | Reply byte valid |
| hst_dout | output | 8 | Reply byte |
| ce | input | 1 | Transmit start pulse input |
| air_tx_valid | output | 1 | Outbound byte valid |
| air_tx_data | output | 8 | Outbound byte |
| air_tx_last | output | 1 | Final byte of the outbound payload |
| air_tx_done | input | 1 | Air side reports the payload sent |
| air_rx_vld | input | 1 | Inbound byte valid |
| air_rx_sop | input | 1 | First byte of an inbound payload |
| air_rx_data | input | 8 | Inbound byte |
| tx_empty | output | 1 | Outbound queue empty |
| tx_full | output | 1 | Outbound queue holds three payloads |
| rx_empty | output | 1 | Inbound queue empty |
| rx_full | output | 1 | Inbound queue holds three payloads |
| reuse_on | output | 1 | Reuse mode active |

## Verification
The outbound queue has two writers of its count: the host finishing a load and the transmit side popping a payload that has been sent. Both can act on the same clock edge. The bench provokes this by sending a payload, waiting until its last byte has appeared, and then loading a new payload. It drives the final host byte of that load together with `air_tx_done`. The result is judged by the flags, which must show neither empty nor full, and by the scoreboard, which checks that the next two pulses send the older queued payload and then the new one, byte for byte.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam logic [7:0] OPC_TX_LOAD  = 8'hA0;
  localparam logic [7:0] OPC_RX_READ  = 8'h61;
  localparam logic [7:0] OPC_TX_FLUSH = 8'hE1;
  localparam logic [7:0] OPC_RX_FLUSH = 8'hE2;
  localparam logic [7:0] OPC_REUSE    = 8'hE3;
  localparam logic [7:0] OPC_STATUS   = 8'h17;

  typedef enum logic [2:0] {HM_OPC, HM_TXLD, HM_RXRD, HM_STAT, HM_SKIP} host_mode_t;
  typedef enum logic [1:0] {TS_IDLE, TS_SEND, TS_WAIT} tx_state_t;
endpackage

// File: rtl/pfq_queue.sv
module pfq_queue #(
  parameter int DEPTH = 3,
  parameter int MAXB  = 32,
  parameter int LENW  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic [LENW-1:0] len,
  input  logic            wr_begin,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            wr_abort,
  input  logic            rd_en,
  input  logic            pop,
  output logic [7:0]      rd_data,
  output logic            q_empty,
  output logic            q_full
);
  localparam int SLW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDXW = $clog2(MAXB);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int AW   = $clog2(DEPTH * MAXB);

  logic [7:0]      mem [DEPTH*MAXB];
  logic [SLW-1:0]  wr_ptr, rd_ptr;
  logic [CNTW-1:0] cnt, cnt_nxt;
  logic            wr_act;
  logic [IDXW-1:0] wr_idx, rd_idx, wr_cur;
  logic            wr_go, wr_fire, wr_last, rd_fire, rd_last, pop_fire;

  function automatic logic [SLW-1:0] slot_next(input logic [SLW-1:0] s);
    return (s == SLW'(DEPTH - 1)) ? '0 : s + SLW'(1);
  endfunction

  function automatic logic [AW-1:0] addr_of(input logic [SLW-1:0] s, input logic [IDXW-1:0] i);
    return AW'(s) * AW'(MAXB) + AW'(i);
  endfunction

  always_comb begin
    wr_go    = wr_begin ? !q_full : wr_act;
    wr_cur   = wr_begin ? '0 : wr_idx;
    wr_fire  = wr_en && wr_go;
    wr_last  = wr_fire && (LENW'(wr_cur) == len - LENW'(1));
    rd_fire  = rd_en && !q_empty;
    rd_last  = (LENW'(rd_idx) == len - LENW'(1));
    pop_fire = pop && !q_empty;
    cnt_nxt  = cnt;
    if (wr_last && !pop_fire)      cnt_nxt = cnt + CNTW'(1);
    else if (!wr_last && pop_fire) cnt_nxt = cnt - CNTW'(1);
  end

  // storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_fire) mem[addr_of(wr_ptr, wr_cur)] <= wr_data;
    if (rd_fire) rd_data <= mem[addr_of(rd_ptr, rd_idx)];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      wr_act  <= 1'b0;
      wr_idx  <= '0;
      rd_idx  <= '0;
      q_empty <= 1'b1;
      q_full  <= 1'b0;
    end else begin
      if (wr_begin) begin
        wr_act <= !q_full;
        wr_idx <= '0;
      end
      if (wr_fire) begin
        if (wr_last) begin
          wr_act <= 1'b0;
          wr_idx <= '0;
          wr_ptr <= slot_next(wr_ptr);
        end else begin
          wr_idx <= wr_cur + IDXW'(1);
        end
      end
      if (wr_abort) wr_act <= 1'b0;
      if (rd_fire) rd_idx <= rd_last ? '0 : rd_idx + IDXW'(1);
      if (pop_fire) begin
        rd_ptr <= slot_next(rd_ptr);
        rd_idx <= '0;
      end
      cnt     <= cnt_nxt;
      q_empty <= (cnt_nxt == '0);
      q_full  <= (cnt_nxt == CNTW'(DEPTH));
    end
  end
endmodule

// File: rtl/pfq_ce_detect.sv
module pfq_ce_detect #(
  parameter int MIN_CYC = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  output logic trig
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] run;
  logic          ce_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      ce_q <= 1'b0;
      trig <= 1'b0;
    end else begin
      ce_q <= ce;
      trig <= ce_q && !ce && (run == CW'(MIN_CYC));
      if (!ce)                       run <= '0;
      else if (run != CW'(MIN_CYC))  run <= run + CW'(1);
    end
  end
endmodule

// File: rtl/pfq_host_ctl.sv
module pfq_host_ctl
  import pfq_pkg::*;
#(
  parameter int LENW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LENW-1:0] len,
  input  logic            hst_cs,
  input  logic            hst_vld,
  input  logic [7:0]      hst_din,
  input  logic            tx_empty,
  input  logic            tx_full,
  input  logic            rx_empty,
  input  logic            rx_full,
  input  logic [7:0]      rx_rd_data,
  output logic            tx_wr_begin,
  output logic            tx_wr_en,
  output logic [7:0]      tx_wr_data,
  output logic            tx_wr_abort,
  output logic            tx_flush,
  output logic            rx_rd_en,
  output logic            rx_pop,
  output logic            rx_flush,
  output logic            reuse_on,
  output logic            hst_dvld,
  output logic [7:0]      hst_dout
);
  host_mode_t      mode;
  logic [LENW-1:0] bcnt;
  logic            cs_q, resp_rx_q;
  logic [7:0]      resp_q, status_byte;
  logic            acc, is_opc, in_rng;

  always_comb begin
    acc         = hst_cs && hst_vld;
    is_opc      = acc && (mode == HM_OPC);
    in_rng      = bcnt < len;
    status_byte = {1'b0, reuse_on, tx_full, tx_empty, 2'b00, rx_full, rx_empty};
    tx_wr_data  = hst_din;
    tx_wr_begin = is_opc && (hst_din == OPC_TX_LOAD);
    tx_flush    = is_opc && (hst_din == OPC_TX_FLUSH);
    rx_flush    = is_opc && (hst_din == OPC_RX_FLUSH);
    tx_wr_en    = acc && (mode == HM_TXLD) && in_rng;
    rx_rd_en    = acc && (mode == HM_RXRD) && in_rng;
    rx_pop      = rx_rd_en && (bcnt == len - LENW'(1));
    tx_wr_abort = cs_q && !hst_cs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= HM_OPC;
      bcnt      <= '0;
      cs_q      <= 1'b0;
      resp_rx_q <= 1'b0;
      resp_q    <= '0;
      hst_dvld  <= 1'b0;
      reuse_on  <= 1'b0;
    end else begin
      cs_q      <= hst_cs;
      hst_dvld  <= acc;
      resp_rx_q <= rx_rd_en;
      if (!hst_cs) begin
        mode <= HM_OPC;
        bcnt <= '0;
      end else if (is_opc) begin
        bcnt   <= '0;
        resp_q <= status_byte;
        if (hst_din == OPC_TX_LOAD)      mode <= HM_TXLD;
        else if (hst_din == OPC_RX_READ) mode <= rx_empty ? HM_SKIP : HM_RXRD;
        else if (hst_din == OPC_STATUS)  mode <= HM_STAT;
        else                             mode <= HM_SKIP;
        if (hst_din == OPC_REUSE) reuse_on <= 1'b1;
      end else if (acc) begin
        if (in_rng) bcnt <= bcnt + LENW'(1);
        resp_q <= (mode == HM_STAT && bcnt == '0) ? status_byte : 8'h00;
      end
      if (tx_flush || rx_flush) reuse_on <= 1'b0;
    end
  end

  assign hst_dout = resp_rx_q ? rx_rd_data : resp_q;
endmodule

// File: rtl/pfq_payload_fifo.sv
module pfq_payload_fifo
  import pfq_pkg::*;
#(
  parameter int DEPTH      = 3,
  parameter int MAXB       = 32,
  parameter int CE_MIN_CYC = 1250,
  localparam int LENW      = $clog2(MAXB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LENW-1:0] cfg_len,
  input  logic            hst_cs,
  input  logic            hst_vld,
  input  logic [7:0]      hst_din,
  output logic            hst_dvld,
  output logic [7:0]      hst_dout,
  input  logic            ce,
  output logic            air_tx_valid,
  output logic [7:0]      air_tx_data,
  output logic            air_tx_last,
  input  logic            air_tx_done,
  input  logic            air_rx_vld,
  input  logic            air_rx_sop,
  input  logic [7:0]      air_rx_data,
  output logic            tx_empty,
  output logic            tx_full,
  output logic            rx_empty,
  output logic            rx_full,
  output logic            reuse_on
);
  logic [LENW-1:0] len_eff, scnt;
  logic            ce_trig;
  logic            tx_wr_begin, tx_wr_en, tx_wr_abort, tx_flush, tx_rd_en, tx_pop;
  logic [7:0]      tx_wr_data, rx_rd_data;
  logic            rx_rd_en, rx_pop, rx_flush;
  tx_state_t       tstate;
  logic            last_q;

  always_comb begin
    if (cfg_len == '0)                  len_eff = LENW'(1);
    else if (cfg_len > LENW'(MAXB))     len_eff = LENW'(MAXB);
    else                                len_eff = cfg_len;
  end

  pfq_ce_detect #(.MIN_CYC(CE_MIN_CYC)) u_ce (
    .clk(clk), .rst(rst), .ce(ce), .trig(ce_trig)
  );

  pfq_host_ctl #(.LENW(LENW)) u_host (
    .clk(clk), .rst(rst), .len(len_eff),
    .hst_cs(hst_cs), .hst_vld(hst_vld), .hst_din(hst_din),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_rd_data(rx_rd_data),
    .tx_wr_begin(tx_wr_begin), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_wr_abort(tx_wr_abort), .tx_flush(tx_flush),
    .rx_rd_en(rx_rd_en), .rx_pop(rx_pop), .rx_flush(rx_flush),
    .reuse_on(reuse_on), .hst_dvld(hst_dvld), .hst_dout(hst_dout)
  );

  pfq_queue #(.DEPTH(DEPTH), .MAXB(MAXB), .LENW(LENW)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .len(len_eff),
    .wr_begin(tx_wr_begin), .wr_en(tx_wr_en), .wr_data(tx_wr_data), .wr_abort(tx_wr_abort),
    .rd_en(tx_rd_en), .pop(tx_pop), .rd_data(air_tx_data),
    .q_empty(tx_empty), .q_full(tx_full)
  );

  pfq_queue #(.DEPTH(DEPTH), .MAXB(MAXB), .LENW(LENW)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .len(len_eff),
    .wr_begin(air_rx_vld && air_rx_sop), .wr_en(air_rx_vld), .wr_data(air_rx_data),
    .wr_abort(1'b0),
    .rd_en(rx_rd_en), .pop(rx_pop), .rd_data(rx_rd_data),
    .q_empty(rx_empty), .q_full(rx_full)
  );

  // transmit sequencer: stream head payload, then wait for the air side
  assign tx_rd_en = (tstate == TS_SEND);
  assign tx_pop   = (tstate == TS_WAIT) && air_tx_done && !reuse_on;

  always_ff @(posedge clk) begin
    if (rst || tx_flush) begin
      tstate       <= TS_IDLE;
      scnt         <= '0;
      air_tx_valid <= 1'b0;
      last_q       <= 1'b0;
    end else begin
      air_tx_valid <= tx_rd_en;
      last_q       <= tx_rd_en && (scnt == len_eff - LENW'(1));
      case (tstate)
        TS_IDLE: if (ce_trig && !tx_empty) begin
          tstate <= TS_SEND;
          scnt   <= '0;
        end
        TS_SEND: begin
          scnt <= scnt + LENW'(1);
          if (scnt == len_eff - LENW'(1)) tstate <= TS_WAIT;
        end
        TS_WAIT: if (air_tx_done) tstate <= TS_IDLE;
        default: tstate <= TS_IDLE;
      endcase
    end
  end

  assign air_tx_last = last_q;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int CE_MIN_CYC = 1250
) (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic ce_trig,
  input logic hst_cs,
  input logic hst_vld,
  input logic hst_dvld,
  input logic air_tx_valid,
  input logic air_tx_last,
  input logic air_tx_done,
  input logic air_rx_vld,
  input logic tx_empty,
  input logic tx_full,
  input logic rx_empty,
  input logic reuse_on,
  input logic tx_pop,
  input logic tx_flush,
  input logic rx_flush
);
  localparam int CW = $clog2(CE_MIN_CYC + 1);
  logic [CW-1:0] hi_run, prev_run;
  logic          ce_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run   <= '0;
      prev_run <= '0;
      ce_prev  <= 1'b0;
    end else begin
      ce_prev <= ce;
      if (ce_prev && !ce) prev_run <= hi_run;
      if (!ce) hi_run <= '0;
      else if (hi_run != CW'(CE_MIN_CYC)) hi_run <= hi_run + CW'(1);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (tx_empty && rx_empty && !reuse_on && !air_tx_valid));

  // R4
  pulse_min_chk: assert property (@(posedge clk) disable iff (rst)
    ce_trig |-> (prev_run == CW'(CE_MIN_CYC)));

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    air_tx_last |-> air_tx_valid);

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_full && !tx_pop && !tx_flush) |=> tx_full);

  // R6
  reuse_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (reuse_on && air_tx_done && !tx_empty && !tx_flush) |=> !tx_empty);

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_flush || rx_flush) |=> !reuse_on);

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_empty && !air_rx_vld) |=> rx_empty);

  // R12
  reply_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_cs && hst_vld) |=> hst_dvld);
endmodule

bind pfq_payload_fifo pfq_checker #(.CE_MIN_CYC(CE_MIN_CYC)) u_pfq_chk (
  .clk(clk), .rst(rst), .ce(ce), .ce_trig(ce_trig),
  .hst_cs(hst_cs), .hst_vld(hst_vld), .hst_dvld(hst_dvld),
  .air_tx_valid(air_tx_valid), .air_tx_last(air_tx_last), .air_tx_done(air_tx_done),
  .air_rx_vld(air_rx_vld), .tx_empty(tx_empty), .tx_full(tx_full),
  .rx_empty(rx_empty), .reuse_on(reuse_on), .tx_pop(tx_pop),
  .tx_flush(tx_flush), .rx_flush(rx_flush)
);

// File: tb/test_pfq_payload_fifo.sv
module test_pfq_payload_fifo;
  localparam int MINC = 20;
  localparam int LEN  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cfg_len = 6'(LEN);
  logic       hst_cs = 0, hst_vld = 0;
  logic [7:0] hst_din = 0;
  logic       hst_dvld;
  logic [7:0] hst_dout;
  logic       ce = 0;
  logic       air_tx_valid, air_tx_last;
  logic [7:0] air_tx_data;
  logic       air_tx_done = 0;
  logic       air_rx_vld = 0, air_rx_sop = 0;
  logic [7:0] air_rx_data = 0;
  logic       tx_empty, tx_full, rx_empty, rx_full, reuse_on;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [8:0] exp_air [$];
  int         tx_mdl [$];
  int         rx_mdl [$];
  bit         reuse_mdl = 0;
  logic [7:0] r;

  always #4 clk = ~clk;

  pfq_payload_fifo #(.DEPTH(3), .MAXB(32), .CE_MIN_CYC(MINC)) i_pfq_payload_fifo (
    .clk(clk), .rst(rst), .cfg_len(cfg_len),
    .hst_cs(hst_cs), .hst_vld(hst_vld), .hst_din(hst_din),
    .hst_dvld(hst_dvld), .hst_dout(hst_dout), .ce(ce),
    .air_tx_valid(air_tx_valid), .air_tx_data(air_tx_data), .air_tx_last(air_tx_last),
    .air_tx_done(air_tx_done), .air_rx_vld(air_rx_vld), .air_rx_sop(air_rx_sop),
    .air_rx_data(air_rx_data), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_full(rx_full), .reuse_on(reuse_on)
  );

  function automatic logic [7:0] pat(input int id, input int i);
    return {id[3:0], i[3:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for the outbound air stream (R4 R5 R6 R11)
  always @(negedge clk) begin
    if (!rst && air_tx_valid) begin
      if (exp_air.size() == 0) begin
        chk(0, "R4 unexpected air byte", {air_tx_last, air_tx_data}, 0);
      end else begin
        logic [8:0] e;
        e = exp_air.pop_front();
        chk({air_tx_last, air_tx_data} == e, "R4 air byte", {air_tx_last, air_tx_data}, e);
      end
    end
  end

  task automatic host_byte(input logic [7:0] b, output logic [7:0] resp);
    hst_cs = 1; hst_vld = 1; hst_din = b;
    @(negedge clk);
    chk(hst_dvld == 1'b1, "R12 reply valid", hst_dvld, 1);
    resp = hst_dout;
    hst_vld = 0;
  endtask

  task automatic end_frame();
    hst_cs = 0; hst_vld = 0;
    @(negedge clk);
  endtask

  task automatic load_tx(input int id);
    logic [7:0] x;
    host_byte(8'hA0, x);
    for (int i = 0; i < LEN; i++) host_byte(pat(id, i), x);
    end_frame();
    if (tx_mdl.size() < 3) tx_mdl.push_back(id);
  endtask

  task automatic command(input logic [7:0] op);
    logic [7:0] x;
    host_byte(op, x);
    end_frame();
  endtask

  task automatic pulse_ce(input int n);
    ce = 1;
    repeat (n) @(negedge clk);
    ce = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic push_exp(input int id);
    for (int i = 0; i < LEN; i++) exp_air.push_back({(i == LEN - 1), pat(id, i)});
  endtask

  task automatic wait_last();
    int n = 0;
    while (!(air_tx_valid && air_tx_last) && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n < 200, "R4 last byte seen", n, 0);
  endtask

  task automatic send_head();
    bit had = (tx_mdl.size() != 0);
    if (had) push_exp(tx_mdl[0]);
    pulse_ce(MINC);
    if (had) begin
      wait_last();
      air_tx_done = 1;
      @(negedge clk);
      air_tx_done = 0;
      if (!reuse_mdl) void'(tx_mdl.pop_front());
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic rx_push(input int id);
    for (int i = 0; i < LEN; i++) begin
      air_rx_vld = 1; air_rx_sop = (i == 0); air_rx_data = pat(id, i);
      @(negedge clk);
    end
    air_rx_vld = 0; air_rx_sop = 0;
    @(negedge clk);
    if (rx_mdl.size() < 3) rx_mdl.push_back(id);
  endtask

  task automatic rx_read();
    logic [7:0] x;
    bit had = (rx_mdl.size() != 0);
    int id = had ? rx_mdl[0] : 0;
    host_byte(8'h61, x);
    for (int i = 0; i < LEN; i++) begin
      host_byte(8'h00, x);
      chk(x == (had ? pat(id, i) : 8'h00), "R9 read byte", x, had ? pat(id, i) : 0);
    end
    end_frame();
    if (had) void'(rx_mdl.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk({tx_empty, tx_full, rx_empty, rx_full, reuse_on, air_tx_valid} == 6'b101000,
        "R1 reset flags", {tx_empty, tx_full, rx_empty, rx_full, reuse_on, air_tx_valid}, 6'b101000);

    // R10 status read on an idle block
    host_byte(8'h17, r);
    chk(r == 8'h11, "R10 opcode reply", r, 8'h11);
    host_byte(8'h00, r);
    chk(r == 8'h11, "R10 status byte", r, 8'h11);
    end_frame();

    // R2 three loads fill the queue
    load_tx(1); load_tx(2);
    chk(!tx_full && !tx_empty, "R2 two stored", {tx_full, tx_empty}, 0);
    load_tx(3);
    chk(tx_full == 1'b1, "R2 full at three", tx_full, 1);
    host_byte(8'h17, r); host_byte(8'h00, r); end_frame();
    chk(r == 8'h21, "R10 status full", r, 8'h21);

    // R3 load into a full queue is dropped
    load_tx(4);
    chk(tx_full == 1'b1, "R3 still full", tx_full, 1);

    // R4 short pulse ignored
    pulse_ce(MINC - 1);
    repeat (10) @(negedge clk);
    chk(tx_full == 1'b1 && exp_air.size() == 0, "R4 short pulse ignored", tx_full, 1);

    // R4 R5 send in order, payload 4 must never appear
    send_head(); send_head();
    chk(!tx_full && !tx_empty, "R5 one left", {tx_full, tx_empty}, 0);
    send_head();
    chk(tx_empty == 1'b1, "R5 drained", tx_empty, 1);
    pulse_ce(MINC);
    repeat (10) @(negedge clk);
    chk(exp_air.size() == 0, "R4 pulse on empty queue", exp_air.size(), 0);

    // R11 load completes in the cycle the sent payload is popped
    load_tx(5); load_tx(6);
    push_exp(5);
    pulse_ce(MINC);
    wait_last();
    host_byte(8'hA0, r);
    for (int i = 0; i < LEN - 1; i++) host_byte(pat(7, i), r);
    air_tx_done = 1;
    host_byte(pat(7, LEN - 1), r);
    air_tx_done = 0;
    end_frame();
    void'(tx_mdl.pop_front());
    tx_mdl.push_back(7);
    chk(!tx_full && !tx_empty, "R11 count after collision", {tx_full, tx_empty}, 0);
    send_head(); send_head();
    chk(tx_empty == 1'b1, "R11 drained", tx_empty, 1);

    // R6 reuse keeps the head
    load_tx(8);
    command(8'hE3);
    reuse_mdl = 1;
    chk(reuse_on == 1'b1, "R6 reuse on", reuse_on, 1);
    host_byte(8'h17, r); host_byte(8'h00, r); end_frame();
    chk(r == 8'h41, "R10 status reuse", r, 8'h41);
    send_head(); send_head();
    chk(tx_empty == 1'b0, "R6 head kept", tx_empty, 0);

    // R7 outbound flush
    command(8'hE1);
    reuse_mdl = 0;
    tx_mdl.delete();
    chk(tx_empty && !reuse_on, "R7 tx flush", {tx_empty, reuse_on}, 2);
    pulse_ce(MINC);
    repeat (10) @(negedge clk);

    // R8 inbound fill and drop
    rx_push(10); rx_push(11); rx_push(12);
    chk(rx_full && !rx_empty, "R8 rx full", {rx_full, rx_empty}, 2);
    rx_push(13);
    chk(rx_full == 1'b1, "R8 dropped while full", rx_full, 1);

    // R9 read three, then empty read
    rx_read(); rx_read(); rx_read();
    chk(rx_empty == 1'b1, "R9 rx drained", rx_empty, 1);
    rx_read();
    chk(rx_empty == 1'b1, "R9 empty read no effect", rx_empty, 1);

    // R7 inbound flush then normal use
    rx_push(14);
    command(8'hE2);
    rx_mdl.delete();
    chk(rx_empty == 1'b1, "R7 rx flush", rx_empty, 1);
    rx_push(15);
    rx_read();

    repeat (5) @(negedge clk);
    chk(exp_air.size() == 0, "R4 all expected bytes seen", exp_air.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule